// File: doc/BRIEF.md
# Frame-Synchronous Register Commit and Interrupt Unit

This block collects register updates from a host and holds them back until the display is between frames. Each update is an entry made of a register address, a keep-mask and a value. The host pushes entries into a queue of 16 slots. It then pushes a closing entry whose address is all ones, which arms the unit. When the timing generator next reports that the active frame has finished, the unit drains the whole queue into the register file, one entry per clock. Each entry is either a plain write or a read-modify-write against a shadow copy of the register file.

The same block keeps the interrupt state for the display pipe. It has status and enable bits for vsync, frame-done and two FIFO-underflow sources, and it drives a single interrupt line. It also emits a vblank-completion pulse on vsync, but only when no commit is outstanding, so the host never hears that a frame is done while its update is still waiting. When a commit starts, the frame-done enable is cleared, so that interrupt fires once per armed update.

Top module: `frame_commit_irq`

## Requirements
- R1: A push whose address is all ones (15 at the default 4-bit address) is never stored or written. When no commit is running, it sets the pending flag `upd_pending` and sets the frame-done enable bit.
- R2: No register-file write occurs unless an update was pending in the previous cycle. Writes happen only after a frame-done event arrives while the unit is armed.
- R3: Once a commit starts, the queued entries appear on the register-file write port one per clock in push order. The first write appears one clock after the frame-done event is sampled.
- R4: An entry with a nonzero mask writes (shadow & mask) | value, where shadow holds the last value written to that address (zero after reset). An entry with a zero mask writes its value unchanged.
- R5: Frame-done enable (status/enable bit 1) is cleared when a commit starts. `upd_pending` drops in the same clock edge that produces the last write.
- R6: A push is dropped, and `push_drop` pulses for one cycle, in two cases: the queue already holds 16 entries, or a commit is draining.
- R7: `vblank_done` pulses one cycle after a vsync event, and only if no update was pending when the event was sampled.
- R8: Events set sticky status bits at these positions: bit 0 vsync, bit 1 frame-done, bit 2+k underflow k. An event in the same cycle as a clear is kept.
- R9: `irq` is high, one cycle after the cause, exactly when some status bit is set together with its enable bit.
- R10: If an enable write, or the arm of R1, newly sets an enable bit whose status bit is already set, the whole status register is cleared.
- R11: A status read returns the status held before the read on `stat_rdata`. It clears the status only when `clr_on_rd` is high.
- R12: An acknowledge clears the whole status register.
- R13: A frame-done event while armed with an empty queue clears `upd_pending` and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Host pushes one queue entry |
| push_addr | input | AW | Entry register address; all ones arms the commit |
| push_mask | input | DW | Keep-mask for read-modify-write; zero means plain write |
| push_value | input | DW | Value to merge or write |
| push_drop | output | 1 | One-cycle pulse when a push was discarded |
| upd_pending | output | 1 | An armed update has not finished committing |
| en_wr | input | 1 | Host writes the interrupt enable register |
| en_wdata | input | NUF+2 | New enable bits |
| clr_on_rd | input | 1 | Status is cleared by a read |
| stat_rd | input | 1 | Host reads the status register |
| stat_ack | input | 1 | Host acknowledges (clears) the status register |
| stat_rdata | output | NUF+2 | Status captured by the last read |
| ev_vsync | input | 1 | Vsync event pulse |
| ev_frame_done | input | 1 | End-of-active-frame event pulse |
| ev_underflow | input | NUF | FIFO underflow event pulses |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | AW | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| irq | output | 1 | Interrupt line |
| vblank_done | output | 1 | Vblank-completion pulse to the host |

## Verification
The assertions assume that every input is held low while reset is high. They also assume the address and event inputs are ordinary single-cycle samples, so the previous-cycle value of an input names the cause of an output change. The bench keeps to this by driving inputs only on the falling clock edge and by holding everything at zero until reset is released. Beyond that it imposes no ordering between pushes, arms, events and host accesses, because its reference model resolves same-cycle collisions the same way the requirements do.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_APPLY} fci_state_e;
  localparam int SRC_VSYNC = 0;
  localparam int SRC_FDONE = 1;
  localparam int SRC_UF0   = 2;
endpackage

// File: rtl/fci_entry_queue.sv
module fci_entry_queue #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [AW-1:0]                waddr,
  input  logic [DW-1:0]                wmask,
  input  logic [DW-1:0]                wval,
  input  logic                         clr,
  input  logic [$clog2(DEPTH)-1:0]     ridx,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [AW-1:0]                raddr,
  output logic [DW-1:0]                rmask,
  output logic [DW-1:0]                rval
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int EW = AW + 2*DW;

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] widx;

  assign widx = clr ? '0 : cnt_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (wr) mem[widx] <= {waddr, wmask, wval};
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= CW'(wr);
    else          cnt_q <= cnt_q + CW'(wr);
  end

  assign cnt = cnt_q;
  assign {raddr, rmask, rval} = mem[ridx];
endmodule

// File: rtl/fci_rmw_port.sv
module fci_rmw_port #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] val,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata
);
  localparam int NREG = 2**AW;

  logic [DW-1:0] shadow [NREG];
  logic [DW-1:0] merged;

  always_comb begin
    if (|mask) merged = (shadow[addr] & mask) | val;
    else       merged = val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else begin
      rf_we <= go;
      if (go) begin
        rf_addr      <= addr;
        rf_wdata     <= merged;
        shadow[addr] <= merged;
      end
    end
  end
endmodule

// File: rtl/fci_irq_ctl.sv
module fci_irq_ctl #(
  parameter int NSRC   = 4,
  parameter int FD_BIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            arm_fd,
  input  logic            disarm_fd,
  input  logic            clr_on_rd,
  input  logic            stat_rd,
  input  logic            stat_ack,
  input  logic [NSRC-1:0] ev,
  output logic [NSRC-1:0] stat_rdata,
  output logic            irq
);
  logic [NSRC-1:0] en_q, en_n, stat_q, stat_n, newly;
  logic            stale;

  always_comb begin
    en_n = en_wr ? en_wdata : en_q;
    if (arm_fd)    en_n[FD_BIT] = 1'b1;
    if (disarm_fd) en_n[FD_BIT] = 1'b0;
    newly  = en_n & ~en_q;
    stale  = |(newly & stat_q);
    stat_n = stat_q;
    if ((stat_rd && clr_on_rd) || stat_ack || stale) stat_n = '0;
    stat_n = stat_n | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      stat_q     <= '0;
      stat_rdata <= '0;
      irq        <= 1'b0;
    end else begin
      en_q   <= en_n;
      stat_q <= stat_n;
      if (stat_rd) stat_rdata <= stat_q;
      irq <= |(stat_n & en_n);
    end
  end
endmodule

// File: rtl/frame_commit_irq.sv
module frame_commit_irq
  import fci_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NUF   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_mask,
  input  logic [DW-1:0]    push_value,
  output logic             push_drop,
  output logic             upd_pending,
  input  logic             en_wr,
  input  logic [NUF+1:0]   en_wdata,
  input  logic             clr_on_rd,
  input  logic             stat_rd,
  input  logic             stat_ack,
  output logic [NUF+1:0]   stat_rdata,
  input  logic             ev_vsync,
  input  logic             ev_frame_done,
  input  logic [NUF-1:0]   ev_underflow,
  output logic             rf_we,
  output logic [AW-1:0]    rf_addr,
  output logic [DW-1:0]    rf_wdata,
  output logic             irq,
  output logic             vblank_done
);
  localparam int NSRC = NUF + 2;
  localparam int IW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH+1);
  localparam logic [AW-1:0] TERM = {AW{1'b1}};

  fci_state_e    st_q;
  logic [IW-1:0] rptr_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_mask, e_val;
  logic          is_term, busy, push_ok, arm, start, last, q_clr;
  logic          drop_q, vb_q;
  logic [NSRC-1:0] ev;

  assign ev      = {ev_underflow, ev_frame_done, ev_vsync};
  assign is_term = push_valid && (push_addr == TERM);
  assign busy    = (st_q == ST_APPLY);
  assign push_ok = push_valid && !is_term && !busy && (cnt != CW'(DEPTH));
  assign arm     = is_term && !busy;
  assign start   = ev_frame_done && (st_q == ST_ARMED);
  assign last    = busy && ((CW'(rptr_q) + CW'(1)) == cnt);
  assign q_clr   = last || (start && (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rptr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (arm) st_q <= ST_ARMED;
        ST_ARMED: if (start) begin
                    rptr_q <= '0;
                    st_q   <= (cnt == '0) ? ST_IDLE : ST_APPLY;
                  end
        ST_APPLY: begin
                    rptr_q <= rptr_q + IW'(1);
                    if (last) st_q <= ST_IDLE;
                  end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= 1'b0;
      vb_q   <= 1'b0;
    end else begin
      drop_q <= push_valid && !push_ok && !arm;
      vb_q   <= ev_vsync && (st_q == ST_IDLE);
    end
  end

  assign push_drop   = drop_q;
  assign vblank_done = vb_q;
  assign upd_pending = (st_q != ST_IDLE);

  fci_entry_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .wr    (push_ok),
    .waddr (push_addr),
    .wmask (push_mask),
    .wval  (push_value),
    .clr   (q_clr),
    .ridx  (rptr_q),
    .cnt   (cnt),
    .raddr (e_addr),
    .rmask (e_mask),
    .rval  (e_val)
  );

  fci_rmw_port #(.AW(AW), .DW(DW)) u_rmw (
    .clk      (clk),
    .rst      (rst),
    .go       (busy),
    .addr     (e_addr),
    .mask     (e_mask),
    .val      (e_val),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata)
  );

  fci_irq_ctl #(.NSRC(NSRC), .FD_BIT(SRC_FDONE)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .arm_fd     (arm),
    .disarm_fd  (start),
    .clr_on_rd  (clr_on_rd),
    .stat_rd    (stat_rd),
    .stat_ack   (stat_ack),
    .ev         (ev),
    .stat_rdata (stat_rdata),
    .irq        (irq)
  );
endmodule

// File: rtl/fci_checker.sv
module fci_checker #(
  parameter int AW  = 4,
  parameter int NUF = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           push_valid,
  input logic [AW-1:0]  push_addr,
  input logic           en_wr,
  input logic           stat_ack,
  input logic           ev_vsync,
  input logic           ev_frame_done,
  input logic [NUF-1:0] ev_underflow,
  input logic           rf_we,
  input logic [AW-1:0]  rf_addr,
  input logic           irq,
  input logic           vblank_done,
  input logic           push_drop,
  input logic           upd_pending
);
  localparam logic [AW-1:0] TERM = {AW{1'b1}};
  logic any_ev;
  assign any_ev = ev_vsync || ev_frame_done || (|ev_underflow);

  p_term_never_written_r1: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_addr != TERM));

  p_pending_needs_arm_r1: assert property (@(posedge clk) disable iff (rst)
    (upd_pending && !$past(upd_pending)) |-> ($past(push_valid) && ($past(push_addr) == TERM)));

  p_write_needs_pending_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(upd_pending));

  p_pending_end_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_pending) |-> ($past(ev_frame_done) || rf_we));

  p_drop_needs_push_r6: assert property (@(posedge clk) disable iff (rst)
    push_drop |-> $past(push_valid));

  p_vblank_gate_r7: assert property (@(posedge clk) disable iff (rst)
    vblank_done |-> ($past(ev_vsync) && !$past(upd_pending)));

  p_irq_rise_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(irq)) |-> ($past(any_ev) || $past(en_wr) || $past(push_valid)));

  p_ack_quiets_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(stat_ack) && !$past(any_ev)) |-> !irq);
endmodule

bind frame_commit_irq fci_checker #(.AW(AW), .NUF(NUF)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .push_valid    (push_valid),
  .push_addr     (push_addr),
  .en_wr         (en_wr),
  .stat_ack      (stat_ack),
  .ev_vsync      (ev_vsync),
  .ev_frame_done (ev_frame_done),
  .ev_underflow  (ev_underflow),
  .rf_we         (rf_we),
  .rf_addr       (rf_addr),
  .irq           (irq),
  .vblank_done   (vblank_done),
  .push_drop     (push_drop),
  .upd_pending   (upd_pending)
);

// File: tb/test_frame_commit_irq.sv
module test_frame_commit_irq;
  localparam int AW = 4, DW = 32, DEPTH = 16, NUF = 2, NSRC = NUF + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 0; logic [AW-1:0] push_addr = '0;
  logic [DW-1:0] push_mask = '0, push_value = '0;
  logic en_wr = 0; logic [NSRC-1:0] en_wdata = '0;
  logic clr_on_rd = 0, stat_rd = 0, stat_ack = 0;
  logic ev_vsync = 0, ev_frame_done = 0; logic [NUF-1:0] ev_underflow = '0;
  logic push_drop, upd_pending, rf_we, irq, vblank_done;
  logic [NSRC-1:0] stat_rdata; logic [AW-1:0] rf_addr; logic [DW-1:0] rf_wdata;

  always #10 clk = ~clk;

  frame_commit_irq #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NUF(NUF)) i_frame_commit_irq (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_addr(push_addr),
    .push_mask(push_mask), .push_value(push_value), .push_drop(push_drop),
    .upd_pending(upd_pending), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_on_rd(clr_on_rd), .stat_rd(stat_rd), .stat_ack(stat_ack),
    .stat_rdata(stat_rdata), .ev_vsync(ev_vsync), .ev_frame_done(ev_frame_done),
    .ev_underflow(ev_underflow), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .irq(irq), .vblank_done(vblank_done));

  int total = 0, bad = 0;
  int wr_cnt = 0, vb_cnt = 0, drop_cnt = 0;
  logic [DW-1:0] last_wd [16];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] m; logic [DW-1:0] v; } ent_t;
  ent_t mq[$];
  int m_state = 0, m_idx = 0;  // 0 idle, 1 armed, 2 draining
  logic [DW-1:0] m_shadow [16];
  logic [NSRC-1:0] m_en = '0, m_stat = '0;
  logic e_we = 0, e_irq = 0, e_vb = 0, e_drop = 0;
  logic [AW-1:0] e_addr = '0; logic [DW-1:0] e_wd = '0;
  logic [NSRC-1:0] e_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_state = 0; m_idx = 0; m_en = '0; m_stat = '0;
      for (int i = 0; i < 16; i++) m_shadow[i] = '0;
      e_we = 0; e_irq = 0; e_vb = 0; e_drop = 0; e_addr = '0; e_wd = '0; e_rd = '0;
    end else begin
      bit term, ok, armx, startx, busy;
      logic [NSRC-1:0] en_n, s, evv;
      ent_t e;
      busy   = (m_state == 2);
      term   = push_valid && (push_addr == 4'hF);
      ok     = push_valid && !term && !busy && (mq.size() < DEPTH);
      armx   = term && !busy;
      startx = 0;
      e_drop = push_valid && !ok && !armx;
      e_vb   = ev_vsync && (m_state == 0);
      e_we   = 0;
      if (busy) begin
        e = mq[m_idx];
        e_wd = (e.m != 0) ? ((m_shadow[e.a] & e.m) | e.v) : e.v;
        m_shadow[e.a] = e_wd; e_addr = e.a; e_we = 1;
        m_idx++;
        if (m_idx == mq.size()) begin mq.delete(); m_state = 0; end
      end else if (m_state == 1 && ev_frame_done) begin
        startx = 1;
        if (mq.size() == 0) m_state = 0; else begin m_state = 2; m_idx = 0; end
      end else if (m_state == 0 && armx) m_state = 1;
      if (ok) begin e.a = push_addr; e.m = push_mask; e.v = push_value; mq.push_back(e); end
      en_n = en_wr ? en_wdata : m_en;
      if (armx)   en_n[1] = 1'b1;
      if (startx) en_n[1] = 1'b0;
      evv = {ev_underflow, ev_frame_done, ev_vsync};
      s = m_stat;
      if ((stat_rd && clr_on_rd) || stat_ack || ((en_n & ~m_en & m_stat) != 0)) s = '0;
      s |= evv;
      if (stat_rd) e_rd = m_stat;
      m_en = en_n; m_stat = s;
      e_irq = ((s & en_n) != 0);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", "rf_we", 64'(rf_we), 64'(e_we));
      if (e_we) begin
        chk("R3", "rf_addr", 64'(rf_addr), 64'(e_addr));
        chk("R4", "rf_wdata", 64'(rf_wdata), 64'(e_wd));
      end
      chk("R9", "irq", 64'(irq), 64'(e_irq));
      chk("R7", "vblank_done", 64'(vblank_done), 64'(e_vb));
      chk("R11", "stat_rdata", 64'(stat_rdata), 64'(e_rd));
      chk("R6", "push_drop", 64'(push_drop), 64'(e_drop));
      chk("R5", "upd_pending", 64'(upd_pending), 64'(m_state != 0));
      if (rf_we) begin wr_cnt++; last_wd[rf_addr] = rf_wdata; end
      if (vblank_done) vb_cnt++;
      if (push_drop) drop_cnt++;
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic push(logic [AW-1:0] a, logic [DW-1:0] m, logic [DW-1:0] v);
    push_valid = 1; push_addr = a; push_mask = m; push_value = v;
    @(negedge clk); push_valid = 0;
  endtask
  task automatic set_en(logic [NSRC-1:0] d);
    en_wr = 1; en_wdata = d; @(negedge clk); en_wr = 0;
  endtask
  task automatic vsync();   ev_vsync = 1;      @(negedge clk); ev_vsync = 0;      endtask
  task automatic fdone();   ev_frame_done = 1; @(negedge clk); ev_frame_done = 0; endtask
  task automatic uflow(logic [NUF-1:0] u); ev_underflow = u; @(negedge clk); ev_underflow = '0; endtask
  task automatic rd();      stat_rd = 1;       @(negedge clk); stat_rd = 0;       endtask
  task automatic ack();     stat_ack = 1;      @(negedge clk); stat_ack = 0;      endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wc, vc;
    cyc(5); rst = 0; #2;
    chk("R5", "reset upd_pending", 64'(upd_pending), 0);
    chk("R9", "reset irq", 64'(irq), 0);
    chk("R2", "reset rf_we", 64'(rf_we), 0);
    chk("R11", "reset stat_rdata", 64'(stat_rdata), 0);
    chk("R7", "reset vblank_done", 64'(vblank_done), 0);
    @(negedge clk);

    // status / enable basics
    set_en(4'hF); vsync(); #2;
    chk("R8", "irq after vsync", 64'(irq), 1);
    @(negedge clk); rd(); #2;
    chk("R8", "vsync at bit 0", 64'(stat_rdata), 64'h1);
    @(negedge clk); ack(); #2;
    chk("R12", "irq after ack", 64'(irq), 0);
    @(negedge clk);

    // first commit: plain writes and same-address ordering
    push(4'd3, 32'h0, 32'hA5A5_0000);
    push(4'd5, 32'h0, 32'h11);
    push(4'd5, 32'hF0, 32'h2);
    push(4'hF, 32'h0, 32'h0); #2;
    chk("R1", "pending after terminator", 64'(upd_pending), 1);
    @(negedge clk);
    vc = vb_cnt; vsync(); cyc(3); #2;
    chk("R7", "no vblank while pending", 64'(vb_cnt), 64'(vc));
    chk("R2", "no write before frame-done", 64'(wr_cnt), 0);
    @(negedge clk); ack(); fdone(); cyc(6); #2;
    chk("R3", "three writes", 64'(wr_cnt), 3);
    chk("R3", "ordered merge reg5", 64'(last_wd[5]), 64'h12);
    chk("R4", "plain write reg3", 64'(last_wd[3]), 64'hA5A5_0000);
    chk("R5", "pending cleared", 64'(upd_pending), 0);
    chk("R5", "frame-done disarmed, irq low", 64'(irq), 0);
    @(negedge clk); vc = vb_cnt; vsync(); cyc(1); #2;
    chk("R7", "vblank after commit", 64'(vb_cnt), 64'(vc + 1));
    @(negedge clk); ack();

    // second commit: masked merge against the shadow
    push(4'd3, 32'hFFFF_0000, 32'h1234); push(4'hF, 0, 0); fdone(); cyc(4); #2;
    chk("R4", "masked merge reg3", 64'(last_wd[3]), 64'hA5A5_1234);
    @(negedge clk);

    // full queue and push during drain
    wc = wr_cnt;
    for (int i = 0; i < DEPTH + 1; i++) push(AW'(i % 15), 32'h0, 32'(i));
    cyc(1); #2;
    chk("R6", "17th push dropped", 64'(drop_cnt), 1);
    @(negedge clk);
    push(4'hF, 0, 0); fdone(); push(4'd2, 0, 32'hDEAD); cyc(25); #2;
    chk("R6", "push during drain dropped", 64'(drop_cnt), 2);
    chk("R3", "sixteen writes", 64'(wr_cnt), 64'(wc + 16));
    @(negedge clk);

    // empty armed commit
    wc = wr_cnt; push(4'hF, 0, 0); fdone(); cyc(3); #2;
    chk("R13", "empty commit clears pending", 64'(upd_pending), 0);
    chk("R13", "empty commit writes nothing", 64'(wr_cnt), 64'(wc));
    @(negedge clk); ack();

    // stale status cleared by enabling
    set_en(4'h0); uflow(2'b01); #2;
    chk("R8", "disabled source no irq", 64'(irq), 0);
    @(negedge clk); set_en(4'h4); #2;
    chk("R10", "stale bit gives no irq", 64'(irq), 0);
    @(negedge clk); rd(); #2;
    chk("R10", "status wiped on enable", 64'(stat_rdata), 0);
    @(negedge clk);

    // clean-on-read
    clr_on_rd = 1; uflow(2'b01); #2;
    chk("R9", "enabled underflow irq", 64'(irq), 1);
    @(negedge clk); rd(); #2;
    chk("R11", "read returns bit 2", 64'(stat_rdata), 64'h4);
    chk("R11", "read cleared status", 64'(irq), 0);
    @(negedge clk); clr_on_rd = 0;

    // mixed traffic, compared cycle by cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      push_valid    = (r < 30);
      push_addr     = AW'($urandom_range(0, 15));
      push_mask     = ($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'h0;
      push_value    = 32'($urandom);
      en_wr         = ($urandom_range(0, 19) == 0);
      en_wdata      = NSRC'($urandom);
      clr_on_rd     = ($urandom_range(0, 1) == 1);
      stat_rd       = ($urandom_range(0, 9) == 0);
      stat_ack      = ($urandom_range(0, 9) == 0);
      ev_vsync      = ($urandom_range(0, 7) == 0);
      ev_frame_done = ($urandom_range(0, 5) == 0);
      ev_underflow  = NUF'(($urandom_range(0, 11) == 0) ? $urandom : 0);
      @(negedge clk);
    end
    push_valid = 0; en_wr = 0; stat_rd = 0; stat_ack = 0;
    ev_vsync = 0; ev_frame_done = 0; ev_underflow = '0;
    cyc(30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule